// File: doc/BRIEF.md
# Multi-PHY Cell Transmit Poller

This block is the cell-sending side of an ATM layer that shares one 8-bit transmit bus with up to 31 PHY devices. It walks the PHY addresses in rotation. Each address is followed by a cycle on the null address 0x1F, and in that null cycle the addressed PHY answers on the cell-available line. When a PHY that the waiting cell may go to reports room, the block drives that PHY's address again in the next cycle with the active-low enable. It then streams the 53 bytes of the cell on consecutive cycles and marks the first byte with start-of-cell.

Cells reach the block as a byte stream with valid/ready handshaking. Each cell carries a destination mask, which is captured with its first byte. The block holds one complete cell. `src_ready` is high while that store has room. It drops once the 53rd byte is taken and stays low until the last byte of that cell has gone out on the bus. A byte moves on any clock edge where both `src_valid` and `src_ready` are high. The source may insert idle cycles between bytes at will. Polling never stops, not even during a transfer. A detection counts only if it comes while no cell is being sent.

Top module: `utopia_tx_master`

## Requirements
- R1: Polling alternates a PHY-address cycle with a null-address (0x1F) cycle. PHY addresses follow the order 0, 1, …, NUM_PHY-1 and then wrap to 0.
- R2: The cell-available input is acted on only when sampled at the end of a null cycle. It then refers to the address driven in the cycle before. A high level in any other cycle causes no selection.
- R3: When a detection is taken, the next cycle drives the detected address again with `ut_enb_n` low. This is the selection cycle. While no cell is being selected or sent, `ut_enb_n` is high.
- R4: The cycle right after the selection cycle carries the first byte of the cell with `ut_soc` high. `ut_soc` is low in every other cycle.
- R5: The 53 bytes go out on 53 consecutive cycles in the order the source delivered them. `ut_enb_n` stays low from the selection cycle through the last byte.
- R6: `ut_oe` is high exactly in the 53 byte cycles. When it is low, `ut_data` is 0 and `ut_soc` is 0.
- R7: Polling carries on during a transfer. The address cycle after the selection cycle drives the next address in rotation, and null cycles still separate the addresses.
- R8: After the last byte, `ut_enb_n` is high for at least one cycle. Detections that arrive while a cell is being sent are dropped, so a new cell needs a fresh detection.
- R9: The source handshake follows the rules given above. `src_ready` is high after reset, low from the acceptance of byte 53 until the last byte is sent, and high again afterwards.
- R10: A synchronous active-high `rst` drives `ut_addr` to 0x1F, `ut_enb_n` high, and `ut_soc` and `ut_oe` low.
- R11: A PHY is selected only if bit [address] of the cell's destination mask is 1. A ready PHY outside the mask is never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Source byte valid |
| src_ready | output | 1 | Block can take a source byte |
| src_data | input | DATA_W | Source cell byte |
| src_mask | input | NUM_PHY | Destination mask, sampled with the first byte of a cell |
| ut_clav | input | 1 | Cell-available response from the polled PHY |
| ut_addr | output | 5 | PHY address bus (0x1F = null) |
| ut_enb_n | output | 1 | Transmit enable, active low |
| ut_data | output | DATA_W | Cell byte bus |
| ut_soc | output | 1 | Start-of-cell marker |
| ut_oe | output | 1 | Output enable for data and start-of-cell |

## Verification
The bench models PHYs that answer on the cell-available line one cycle after their address, and a scoreboard compares every byte and every selection. In one phase it holds the cell-available line high during every non-null cycle while no PHY is ready. A design that samples in the wrong phase would then select a PHY. In another phase the ready PHYs all lie outside the waiting cell's mask, and a design that ignores the mask would send the cell there. In a back-to-back phase every PHY is ready. That exposes a missing idle cycle after the last byte, polling that stalls or skips an address during a transfer, and a selection that drives the wrong address or a start-of-cell that arrives late.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int ADDR_W     = 5;
  localparam int BYTE_W     = 8;
  localparam int CELL_BYTES = 53;
  localparam int MASK_W     = 32;
  typedef logic [ADDR_W-1:0] phy_addr_t;
  localparam phy_addr_t NULL_ADDR = '1;
endpackage

// File: rtl/utx_poll_seq.sv
module utx_poll_seq
  import utx_pkg::*;
#(
  parameter int NUM_PHY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clav,
  input  logic              cell_ok,
  input  logic [MASK_W-1:0] cand_mask,
  output phy_addr_t         ut_addr,
  output logic              sel_o
);
  localparam phy_addr_t LAST_IDX = phy_addr_t'(NUM_PHY - 1);

  phy_addr_t idx_q;      // next address in rotation
  phy_addr_t last_q;     // address driven in the last poll cycle
  logic      phase_q;    // 0: address cycle, 1: null cycle
  logic      last_vld_q;
  logic      sel_q;
  logic      take;

  // A detection is taken at the end of a null cycle only
  assign take = !sel_q && phase_q && last_vld_q && clav && cell_ok && cand_mask[last_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      last_q     <= NULL_ADDR;
      phase_q    <= 1'b1;
      last_vld_q <= 1'b0;
      sel_q      <= 1'b0;
    end else begin
      sel_q <= take;
      if (sel_q) begin
        phase_q <= 1'b0;
      end else if (!phase_q) begin
        phase_q    <= 1'b1;
        last_q     <= idx_q;
        last_vld_q <= 1'b1;
        idx_q      <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end else if (!take) begin
        phase_q <= 1'b0;
      end
    end
  end

  assign ut_addr = sel_q ? last_q : (phase_q ? NULL_ADDR : idx_q);
  assign sel_o   = sel_q;

  AST_NULL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!sel_q && !phase_q) |=> (ut_addr == NULL_ADDR)); // R1
  AST_SEL_REPEAT: assert property (@(posedge clk) disable iff (rst)
    sel_q |-> ($past(clav) && ut_addr == $past(ut_addr, 2))); // R3
  AST_SEL_IN_MASK: assert property (@(posedge clk) disable iff (rst)
    sel_q |-> cand_mask[ut_addr]); // R11
endmodule

// File: rtl/utx_cell_buf.sv
module utx_cell_buf
  import utx_pkg::*;
#(
  parameter int DATA_W   = BYTE_W,
  parameter int CELL_LEN = CELL_BYTES,
  parameter int NUM_PHY  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        s_valid,
  output logic                        s_ready,
  input  logic [DATA_W-1:0]           s_data,
  input  logic [NUM_PHY-1:0]          s_mask,
  input  logic [$clog2(CELL_LEN)-1:0] rd_idx,
  output logic [DATA_W-1:0]           rd_data,
  input  logic                        free_i,
  output logic                        full_o,
  output logic [NUM_PHY-1:0]          mask_o
);
  localparam int                  CNT_W = $clog2(CELL_LEN);
  localparam logic [CNT_W-1:0]    LAST  = CNT_W'(CELL_LEN - 1);

  logic [DATA_W-1:0]  mem [CELL_LEN];
  logic [CNT_W-1:0]   wr_q;
  logic               full_q;
  logic [NUM_PHY-1:0] mask_q;
  logic               accept;

  assign s_ready = !full_q;
  assign accept  = s_valid && !full_q;

  always_ff @(posedge clk) begin
    if (accept) mem[wr_q] <= s_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= '0;
      full_q <= 1'b0;
      mask_q <= '0;
    end else begin
      if (accept) begin
        if (wr_q == '0) mask_q <= s_mask;
        if (wr_q == LAST) begin
          wr_q   <= '0;
          full_q <= 1'b1;
        end else begin
          wr_q <= wr_q + 1'b1;
        end
      end
      if (free_i) full_q <= 1'b0;
    end
  end

  assign rd_data = mem[rd_idx];
  assign full_o  = full_q;
  assign mask_o  = mask_q;

  AST_FREE_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    free_i |-> full_q); // R9
endmodule

// File: rtl/utx_sender.sv
module utx_sender
  import utx_pkg::*;
#(
  parameter int CELL_LEN = CELL_BYTES
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sel_i,
  output logic [$clog2(CELL_LEN)-1:0] rd_idx,
  output logic                        done_o,
  output logic                        busy_o,
  output logic                        ut_enb_n,
  output logic                        ut_soc,
  output logic                        ut_oe
);
  localparam int               CNT_W = $clog2(CELL_LEN);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(CELL_LEN - 1);

  logic             send_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      send_q <= 1'b0;
      cnt_q  <= '0;
    end else if (sel_i) begin
      send_q <= 1'b1;
      cnt_q  <= '0;
    end else if (send_q) begin
      if (cnt_q == LAST) begin
        send_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rd_idx   = cnt_q;
  assign done_o   = send_q && (cnt_q == LAST);
  assign busy_o   = send_q;
  assign ut_enb_n = !(sel_i || send_q);
  assign ut_oe    = send_q;
  assign ut_soc   = send_q && (cnt_q == '0);

  AST_SOC_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
    sel_i |=> (ut_soc && ut_oe)); // R4
  AST_ENB_DURING_DATA: assert property (@(posedge clk) disable iff (rst)
    ut_oe |-> !ut_enb_n); // R5
  AST_GAP_AFTER_CELL: assert property (@(posedge clk) disable iff (rst)
    done_o |=> ut_enb_n); // R8
endmodule

// File: rtl/utopia_tx_master.sv
module utopia_tx_master
  import utx_pkg::*;
#(
  parameter int NUM_PHY  = 4,
  parameter int DATA_W   = BYTE_W,
  parameter int CELL_LEN = CELL_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               src_valid,
  output logic               src_ready,
  input  logic [DATA_W-1:0]  src_data,
  input  logic [NUM_PHY-1:0] src_mask,
  input  logic               ut_clav,
  output logic [ADDR_W-1:0]  ut_addr,
  output logic               ut_enb_n,
  output logic [DATA_W-1:0]  ut_data,
  output logic               ut_soc,
  output logic               ut_oe
);
  localparam int CNT_W = $clog2(CELL_LEN);

  logic               sel;
  logic               busy;
  logic               done;
  logic               buf_full;
  logic [NUM_PHY-1:0] buf_mask;
  logic [MASK_W-1:0]  mask_ext;
  logic [CNT_W-1:0]   rd_idx;
  logic [DATA_W-1:0]  rd_data;
  logic               cell_ok;

  assign mask_ext = MASK_W'(buf_mask);
  assign cell_ok  = buf_full && !busy;

  utx_poll_seq #(.NUM_PHY(NUM_PHY)) u_poll (
    .clk(clk), .rst(rst), .clav(ut_clav), .cell_ok(cell_ok),
    .cand_mask(mask_ext), .ut_addr(ut_addr), .sel_o(sel)
  );

  utx_cell_buf #(.DATA_W(DATA_W), .CELL_LEN(CELL_LEN), .NUM_PHY(NUM_PHY)) u_buf (
    .clk(clk), .rst(rst), .s_valid(src_valid), .s_ready(src_ready),
    .s_data(src_data), .s_mask(src_mask), .rd_idx(rd_idx), .rd_data(rd_data),
    .free_i(done), .full_o(buf_full), .mask_o(buf_mask)
  );

  utx_sender #(.CELL_LEN(CELL_LEN)) u_send (
    .clk(clk), .rst(rst), .sel_i(sel), .rd_idx(rd_idx), .done_o(done),
    .busy_o(busy), .ut_enb_n(ut_enb_n), .ut_soc(ut_soc), .ut_oe(ut_oe)
  );

  assign ut_data = ut_oe ? rd_data : '0;

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
    !ut_oe |-> (ut_data == '0 && !ut_soc)); // R6
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> ut_oe); // R8
endmodule

// File: tb/sim_utopia_tx_master.sv
`timescale 1ns/1ps
module sim_utopia_tx_master;
  localparam int NP = 4;
  localparam int CL = 53;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          src_valid = 1'b0;
  logic          src_ready;
  logic [7:0]    src_data = '0;
  logic [NP-1:0] src_mask = '0;
  logic          ut_clav = 1'b0;
  logic [4:0]    ut_addr;
  logic          ut_enb_n;
  logic [7:0]    ut_data;
  logic          ut_soc;
  logic          ut_oe;

  always #4 clk = ~clk;

  utopia_tx_master #(.NUM_PHY(NP)) u0 (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .src_mask(src_mask), .ut_clav(ut_clav),
    .ut_addr(ut_addr), .ut_enb_n(ut_enb_n), .ut_data(ut_data),
    .ut_soc(ut_soc), .ut_oe(ut_oe)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] rdy = '0;
  bit noise = 0;
  int sel_count = 0;
  logic [7:0]  exp_q[$];
  logic [31:0] mask_q[$];

  logic [4:0] prev_addr = 5'h1F;
  logic [4:0] prev2_addr = 5'h1F;
  bit prev_enb_n = 1;
  bit prev_poll = 0;
  int exp_poll = 0;
  bit in_cell = 0;
  bit h1_pend = 0;
  bit gap_pend = 0;
  int bidx = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // PHY model and scoreboard monitor, both at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      ut_clav    = 1'b0;
      prev_addr  = 5'h1F;
      prev2_addr = 5'h1F;
      prev_enb_n = 1;
      prev_poll  = 0;
      exp_poll   = 0;
    end else begin
      bit sel_now;
      bit poll_now;
      logic [7:0]  eb;
      logic [31:0] m;
      sel_now  = !ut_enb_n && prev_enb_n;
      poll_now = (ut_addr != 5'h1F) && !sel_now;
      if (prev_poll) chk(ut_addr == 5'h1F, "R1 null after address", int'(ut_addr), 31);
      if (poll_now) begin
        chk(int'(ut_addr) == exp_poll, in_cell ? "R7 poll during cell" : "R1 rotation",
            int'(ut_addr), exp_poll);
        exp_poll = (exp_poll + 1) % NP;
      end
      if (gap_pend) begin
        chk(ut_enb_n == 1'b1, "R8 idle after last byte", int'(ut_enb_n), 1);
        gap_pend = 0;
      end
      if (h1_pend) begin
        chk(ut_oe && ut_soc, "R4 first byte after selection", int'({ut_oe, ut_soc}), 3);
        h1_pend = 0;
        in_cell = 1;
        bidx = 0;
      end
      if (ut_oe) begin
        chk(in_cell, "R6 oe outside cell", 0, 1);
        eb = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hXX;
        chk(ut_data === eb, "R5 byte order", int'(ut_data), int'(eb));
        chk(ut_soc == (bidx == 0), "R4 soc placement", int'(ut_soc), int'(bidx == 0));
        chk(!ut_enb_n, "R5 enable held", int'(ut_enb_n), 0);
        bidx++;
        if (bidx == CL) begin
          in_cell = 0;
          gap_pend = 1;
        end
      end else begin
        chk(ut_data == 8'h00 && !ut_soc, "R6 quiet bus", int'({ut_soc, ut_data}), 0);
      end
      if (sel_now) begin
        sel_count++;
        chk(ut_addr == prev2_addr && rdy[ut_addr], "R3 reselect detected PHY",
            int'(ut_addr), int'(prev2_addr));
        m = (mask_q.size() > 0) ? mask_q.pop_front() : 32'h0;
        chk(m[ut_addr], "R11 target in mask", int'(ut_addr), -1);
        h1_pend = 1;
      end
      ut_clav = (prev_addr == 5'h1F) ? noise : rdy[prev_addr];
      prev2_addr = prev_addr;
      prev_addr  = ut_addr;
      prev_enb_n = ut_enb_n;
      prev_poll  = poll_now;
    end
  end

  // Driver: call at a falling edge; pushes expected bytes as they are accepted
  task automatic send_cell(input logic [NP-1:0] msk, input int base);
    for (int i = 0; i < CL; i++) begin
      if (i % 9 == 4) begin
        src_valid = 1'b0;
        @(negedge clk);
      end
      src_valid = 1'b1;
      src_data  = 8'(base + i * 3);
      src_mask  = msk;
      while (!src_ready) @(negedge clk);
      exp_q.push_back(src_data);
      if (i == 0) mask_q.push_back(32'(msk));
      @(negedge clk);
    end
    src_valid = 1'b0;
  endtask

  task automatic wait_done(input int target, input string req);
    for (int k = 0; k < 3000; k++) begin
      if (sel_count >= target && exp_q.size() == 0 && !in_cell && !h1_pend) break;
      @(negedge clk);
    end
    chk(sel_count == target, req, sel_count, target);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ut_addr == 5'h1F, "R10 reset addr", int'(ut_addr), 31);
    chk(ut_enb_n && !ut_soc && !ut_oe, "R10 reset controls",
        int'({ut_enb_n, ut_soc, ut_oe}), 4);
    chk(src_ready, "R9 ready after reset", int'(src_ready), 1);
    rst = 1'b0;
    @(negedge clk);

    // single cell to PHY 1
    rdy = 32'h2;
    send_cell(4'b0010, 10);
    @(negedge clk);
    chk(!src_ready, "R9 ready low when full", int'(src_ready), 0);
    wait_done(1, "R3 one selection");
    @(negedge clk);
    chk(src_ready, "R9 ready back after send", int'(src_ready), 1);

    // CLAV high in the wrong phase only: no selection
    rdy = '0;
    noise = 1;
    send_cell(4'hF, 50);
    repeat (150) @(negedge clk);
    chk(sel_count == 1, "R2 wrong-phase clav ignored", sel_count, 1);
    chk(!src_ready, "R9 ready held low while waiting", int'(src_ready), 0);
    noise = 0;
    rdy = 32'h8;
    wait_done(2, "R2 selection after true detect");

    // ready PHYs all outside the mask
    rdy = 32'hB;
    send_cell(4'b0100, 90);
    repeat (150) @(negedge clk);
    chk(sel_count == 2, "R11 out-of-mask PHY not selected", sel_count, 2);
    rdy = 32'hF;
    wait_done(3, "R11 in-mask PHY selected");

    // back to back cells with every PHY ready
    send_cell(4'hF, 130);
    send_cell(4'hF, 170);
    send_cell(4'b1001, 210);
    wait_done(6, "R8 back-to-back cells");
    chk(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);
    chk(src_ready, "R9 ready at end", int'(src_ready), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule